// File: doc/BRIEF.md
# Strobe Bus Sequencer

This block is the sole controller of a plain parallel bus. The bus has an address bus and a direction line, both driven only by this block. It has a shared data bus, here split into an output value, an output enable and an input value. A single strobe line marks the moment of transfer. There is no handshake from the far side, so every transfer follows a fixed, programmed timetable. The address is presented first. A programmed wait follows. The strobe is then raised for a programmed number of clocks. After the strobe drops, the bus stays unchanged for one more clock.

Local logic hands over one operation at a time. Each operation carries a type bit, an address and write data. The request is taken only while the ready output is high. When the operation ends, a one-clock done pulse is issued. For reads, the word that was latched as the strobe fell is presented on the same clock as that pulse. Writes wait for the longer of the address wait and the data wait, so the write data has its own setup time before the strobe.

Top module: `strobe_bus_master`

## Requirements
- R1: While reset is high and in the first clock after it, req_ready is 1 and bus_stb, bus_doe and done are 0.
- R2: A request is accepted only at a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the clock after acceptance until the done clock. A request presented while req_ready is 0 is ignored.
- R3: From the clock after acceptance through the hold clock, bus_addr equals the accepted address. bus_dir equals the type bit (1 = write, 0 = read).
- R4: bus_stb first rises in clock W+1 after acceptance, where clock 1 is the first clock after the accepting edge. W is ADDR_WAIT for reads and the larger of ADDR_WAIT and DATA_WAIT for writes. Address and direction do not change at that rise.
- R5: bus_stb stays high for exactly STB_WIDTH consecutive clocks per operation.
- R6: During a read operation, bus_doe stays 0.
- R7: During a write operation, bus_doe is 1 and bus_dout equals the accepted write data from clock 1 through the hold clock. The slave therefore receives that word.
- R8: A read returns on rd_data the value that bus_din held in the last clock of the strobe. Values on bus_din at other times have no effect.
- R9: Exactly one hold clock follows the strobe. In that clock bus_stb is 0, address, direction and write data are unchanged, and req_ready is 0.
- R10: done is high for exactly one clock, the clock after the hold clock. req_ready is 1 in that same clock. For a read, rd_data holds the captured word in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| done | output | 1 | One-clock end-of-operation pulse |
| rd_data | output | DATA_W | Captured read word |
| bus_addr | output | ADDR_W | Address lines |
| bus_dir | output | 1 | Direction line, 1 = write |
| bus_dout | output | DATA_W | Data driven by this block |
| bus_doe | output | 1 | Data drive enable |
| bus_din | input | DATA_W | Data from the bus |
| bus_stb | output | 1 | Strobe |

## Verification
The internal state is one phase and one down-counter. Either of these going wrong shows at the ports within a clock or two. A counter that is off by one moves the strobe rise or fall by a clock against the per-clock reference. A phase that skips the hold clock raises done and req_ready one clock early. A capture on the wrong edge returns the filler word, because the slave model drives the real data only in the last strobe clock. A busy request that slips through shows up as an address change before the done pulse.

// File: rtl/strobe_bus_pkg.sv
package strobe_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/strobe_bus_timer.sv
module strobe_bus_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/strobe_bus_ctrl.sv
module strobe_bus_ctrl
  import strobe_bus_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] rd_wait,
  input  logic [CNT_W-1:0] wr_wait,
  input  logic [CNT_W-1:0] stb_len,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             req_ready,
  output logic             bus_stb,
  output logic             bus_doe,
  output logic             done
);

  phase_t ph;
  logic   wr_q;

  assign accept  = (ph == PH_IDLE) && req_valid;
  assign capture = (ph == PH_STROBE) && tmr_zero && !wr_q;

  // timer reload points: wait before strobe, then strobe width
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? (wr_wait - 1'b1) : (rd_wait - 1'b1);
    end else if ((ph == PH_SETUP) && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = stb_len - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      wr_q      <= 1'b0;
      req_ready <= 1'b1;
      bus_stb   <= 1'b0;
      bus_doe   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (req_valid) begin
            ph        <= PH_SETUP;
            wr_q      <= req_write;
            bus_doe   <= req_write;
            req_ready <= 1'b0;
          end
        end
        PH_SETUP: begin
          if (tmr_zero) begin
            ph      <= PH_STROBE;
            bus_stb <= 1'b1;
          end
        end
        PH_STROBE: begin
          if (tmr_zero) begin
            ph      <= PH_HOLD;
            bus_stb <= 1'b0;
          end
        end
        PH_HOLD: begin
          ph        <= PH_IDLE;
          bus_doe   <= 1'b0;
          req_ready <= 1'b1;
          done      <= 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strobe_bus_datapath.sv
module strobe_bus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_dir,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_dir  <= 1'b0;
      bus_dout <= '0;
    end else if (accept) begin
      bus_addr <= req_addr;
      bus_dir  <= req_write;
      bus_dout <= req_wdata;
    end
  end

  // read word taken at the edge that ends the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (capture) begin
      rd_data <= bus_din;
    end
  end

endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
  import strobe_bus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_WAIT = 2,
  parameter int DATA_WAIT = 3,
  parameter int STB_WIDTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_dir,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_stb
);

  localparam int WR_WAIT = max2(ADDR_WAIT, DATA_WAIT);
  localparam int MAX_CNT = max2(WR_WAIT, STB_WIDTH);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] RD_WAIT_C = CNT_W'(ADDR_WAIT);
  localparam logic [CNT_W-1:0] WR_WAIT_C = CNT_W'(WR_WAIT);
  localparam logic [CNT_W-1:0] STB_LEN_C = CNT_W'(STB_WIDTH);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             accept;
  logic             capture;

  strobe_bus_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  strobe_bus_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .rd_wait   (RD_WAIT_C),
    .wr_wait   (WR_WAIT_C),
    .stb_len   (STB_LEN_C),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .req_ready (req_ready),
    .bus_stb   (bus_stb),
    .bus_doe   (bus_doe),
    .done      (done)
  );

  strobe_bus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_dir   (bus_dir),
    .bus_dout  (bus_dout),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/strobe_bus_checker.sv
module strobe_bus_checker #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int STB_WIDTH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_dir,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_doe,
  input logic              bus_stb
);

  int unsigned stb_run;

  always_ff @(posedge clk) begin
    if (rst) stb_run <= 0;
    else     stb_run <= bus_stb ? stb_run + 1 : 0;
  end

  assert_busy_during_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> !req_ready);

  assert_addr_before_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_stb) |-> ($stable(bus_addr) && $stable(bus_dir)));

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_stb) |-> (stb_run == STB_WIDTH));

  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && !bus_dir) |-> !bus_doe);

  assert_write_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_stb && bus_dir) |-> (bus_doe && $stable(bus_dout)));

  assert_hold_clock_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_stb) |-> ($stable(bus_addr) && $stable(bus_dir) && $stable(bus_dout) && !req_ready));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind strobe_bus_master strobe_bus_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_WIDTH(STB_WIDTH)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
  .bus_addr(bus_addr), .bus_dir(bus_dir), .bus_dout(bus_dout),
  .bus_doe(bus_doe), .bus_stb(bus_stb)
);

// File: tb/tb_strobe_bus_master.sv
`timescale 1ns/1ps
module tb_strobe_bus_master;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int AWAIT = 2;
  localparam int DWAIT = 3;
  localparam int SW = 2;
  localparam int WWAIT = (AWAIT > DWAIT) ? AWAIT : DWAIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, bus_dir, bus_doe, bus_stb;
  logic [DW-1:0] rd_data, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;

  always #2 clk = ~clk;

  strobe_bus_master #(.ADDR_W(AW), .DATA_W(DW), .ADDR_WAIT(AWAIT),
                      .DATA_WAIT(DWAIT), .STB_WIDTH(SW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .bus_addr(bus_addr), .bus_dir(bus_dir),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_stb(bus_stb)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // slave model: real data only in the last strobe clock
  logic [DW-1:0] mem [0:255];
  int scnt = 0;
  initial for (int i = 0; i < 256; i++) mem[i] = DW'(i * 16'h0101 + 16'h3C);

  always_comb begin
    if (bus_stb && scnt == SW - 1) bus_din = mem[bus_addr[7:0]];
    else                           bus_din = 16'hBAD0 ^ bus_addr;
  end

  always @(posedge clk) begin
    if (bus_stb && scnt == SW - 1 && bus_dir) mem[bus_addr[7:0]] <= bus_dout;
    scnt <= bus_stb ? scnt + 1 : 0;
  end

  // reference model
  int t = -1;
  bit e_wr = 0;
  bit e_done = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_data = '0;
  logic [DW-1:0] e_rd = '0;

  function automatic int wait_of(input bit wr);
    return wr ? WWAIT : AWAIT;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      t = -1;
      e_done = 0;
    end else begin
      e_done = 0;
      if (t >= 1) begin
        t++;
        if (t == wait_of(e_wr) + SW + 2) begin
          t = -1;
          e_done = 1;
        end
      end else if (req_valid) begin
        t = 1;
        e_wr = req_write;
        e_addr = req_addr;
        e_data = req_wdata;
        e_rd = mem[req_addr[7:0]];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int w;
      bit exp_stb;
      w = wait_of(e_wr);
      exp_stb = (t > w) && (t <= w + SW);
      chk(req_ready == (t == -1), (t == w + SW + 1) ? "R9 ready in hold" : "R2 ready",
          32'(req_ready), 32'(t == -1));
      chk(bus_stb == exp_stb, (t == w + 1) ? "R4 strobe rise" : "R5 strobe level",
          32'(bus_stb), 32'(exp_stb));
      if (t >= 1) begin
        chk(bus_addr == e_addr, "R3 address", 32'(bus_addr), 32'(e_addr));
        chk(bus_dir == e_wr, "R3 direction", 32'(bus_dir), 32'(e_wr));
        if (e_wr) begin
          chk(bus_doe == 1'b1, "R7 drive enable", 32'(bus_doe), 32'd1);
          chk(bus_dout == e_data, "R7 write data", 32'(bus_dout), 32'(e_data));
        end else begin
          chk(bus_doe == 1'b0, "R6 no drive on read", 32'(bus_doe), 32'd0);
        end
      end else begin
        chk(bus_doe == 1'b0, "R6 idle drive", 32'(bus_doe), 32'd0);
      end
      chk(done == e_done, "R10 done", 32'(done), 32'(e_done));
      if (e_done && !e_wr)
        chk(rd_data == e_rd, "R8 read data", 32'(rd_data), 32'(e_rd));
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && bus_stb == 0 && bus_doe == 0 && done == 0, "R1 in reset",
        {28'd0, req_ready, bus_stb, bus_doe, done}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1 && bus_stb == 0 && bus_doe == 0 && done == 0, "R1 after reset",
        {28'd0, req_ready, bus_stb, bus_doe, done}, 32'h8);

    // writes with gaps, then back-to-back
    do_req(1'b1, 16'h0010, 16'hA5A5); wait_idle();
    do_req(1'b1, 16'h0011, 16'h5A5A); wait_idle(); repeat (2) @(negedge clk);
    do_req(1'b1, 16'h00FF, 16'hFFFF);
    do_req(1'b1, 16'h0000, 16'h0000);
    wait_idle();
    chk(mem[8'h10] == 16'hA5A5, "R7 slave got word", 32'(mem[8'h10]), 32'hA5A5);
    chk(mem[8'hFF] == 16'hFFFF, "R7 slave got word", 32'(mem[8'hFF]), 32'hFFFF);

    // reads back-to-back, including untouched location
    do_req(1'b0, 16'h0010, '0);
    do_req(1'b0, 16'h0011, '0);
    do_req(1'b0, 16'h0042, '0);
    wait_idle();

    // request while busy must be ignored (R2)
    do_req(1'b0, 16'h00FF, '0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0077; req_wdata = 16'h1234;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    chk(mem[8'h77] != 16'h1234, "R2 busy request ignored", 32'(mem[8'h77]), 32'(mem[8'h77]));

    // alternating write/read pattern
    for (int i = 0; i < 6; i++) begin
      do_req(1'b1, AW'(16'h0080 + i), DW'(16'h1000 * i + 7));
      do_req(1'b0, AW'(16'h0080 + i), '0);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule